// File: doc/BRIEF.md
# Dual-Slot Instruction Fetch Sequencer

This block is the control sequencer of a small stored-program machine. Each memory word is twelve 6-bit characters and holds two instructions. The left half runs first and the right half second. A word read brings in both instructions, and no second memory access is needed for the right one. The sequencer keeps a control counter, which holds the address of the next word pair. It also keeps a fetched-word register and a one-instruction register that holds the order being executed. It repeats a fixed stage sequence: address copy, word read, counter increment, left execute, right execute.

The sequencer supports seven orders. Two bring a memory word into working registers, one stores and clears, and one does nothing. The others are a stop, an unconditional transfer and a transfer taken on equality. The 1000-word memory is inside the block. A load port fills it while the machine is halted. After reset the machine waits in the halted state. A one-cycle `start` pulse runs it from the current counter value until a stop order is executed.

Top module: `dual_slot_sequencer`

## Requirements
- R1: While `rst` is high and after it falls, `halted` is 1, `cc_addr` is 000, and `reg_a`, `reg_x` and `reg_l` are all zero.
- R2: `cc_addr` holds three decimal digit codes: hundreds in bits [17:12], tens in [11:6], units in [5:0]. Each fetched word increments it by one in decimal, and 999 wraps to 000.
- R3: A `start` seen while halted clears `halted` on that edge. Word fetches then follow one another, each spanning 9 edges from the edge after the previous word ends (or after the start edge). The counter updates on edge 3 of a word, left-half effects appear on edge 6 and right-half effects on edge 9. A word's left instruction executes before its right one.
- R4: Bring-A, operation code 20, copies memory[m] into both `reg_a` and `reg_x`. Memory is left unchanged.
- R5: Bring-L, operation code 21, copies memory[m] into both `reg_l` and `reg_x`.
- R6: Store, operation code 22, writes `reg_a` into memory[m] and then sets `reg_a` to all zero codes.
- R7: Operation code 0 (skip), and any code not listed in these requirements, changes no register, no memory word and not the counter. Its address is ignored.
- R8: Stop, operation code 9, sets `halted` on its execute edge. Nothing later in that word runs. While halted, the registers and `cc_addr` hold their values. The next `start` resumes from the current `cc_addr`.
- R9: Transfer, operation code 23, replaces `cc_addr` with m. The following fetch reads word m.
- R10: Conditional transfer, operation code 24, acts as transfer when `reg_a` equals `reg_l` in all 72 bits. Otherwise it acts as skip.
- R11: Character 1 of a word is in bits [71:66]. The left instruction is bits [71:36] and the right is [35:0]. In an instruction, character 1 (top 6 bits) is the operation. Characters 2 and 3 have no effect. Characters 4 to 6 are the address m as hundreds, tens and units digit codes.
- R12: With `ld_en` high, `ld_word` is written to memory at the binary index `ld_addr` on the clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Resume execution when halted |
| ld_en | input | 1 | Memory load strobe |
| ld_addr | input | 10 | Binary load index 0..999 |
| ld_word | input | 72 | Word to load |
| halted | output | 1 | Machine is stopped |
| cc_addr | output | 18 | Control counter address digits |
| reg_a | output | 72 | Accumulator-side working register |
| reg_x | output | 72 | Shared copy register |
| reg_l | output | 72 | Comparison register |

## Verification
Timing is counted from the edge that accepts `start`. The counter moves on the third edge of each 9-edge word period. Left-instruction results are due on the sixth edge and right-instruction results on the ninth. `halted` rises on the execute edge of a stop order. The bench reference advances an edge counter under the same rule and compares every output on each falling edge, half a cycle after the design updates. At each halt, further checks compare the counter and registers with values worked out by hand for the programs: swap, compare, branch, wrap and resume.

// File: rtl/dss_pkg.sv
package dss_pkg;
  parameter int CHAR_W = 6;

  localparam logic [CHAR_W-1:0] OPC_SKIP = CHAR_W'(0);
  localparam logic [CHAR_W-1:0] OPC_STOP = CHAR_W'(9);
  localparam logic [CHAR_W-1:0] OPC_BRA  = CHAR_W'(20);
  localparam logic [CHAR_W-1:0] OPC_BRL  = CHAR_W'(21);
  localparam logic [CHAR_W-1:0] OPC_STO  = CHAR_W'(22);
  localparam logic [CHAR_W-1:0] OPC_JMP  = CHAR_W'(23);
  localparam logic [CHAR_W-1:0] OPC_CJMP = CHAR_W'(24);

  typedef enum logic [2:0] {
    S_IDLE, S_ST1, S_ST2, S_ST3, S_LDL, S_LDR, S_EXA, S_EXB
  } stage_e;

  typedef enum logic [2:0] {
    K_NOP, K_BRA, K_BRL, K_STO, K_JMP, K_CJMP, K_STOP
  } kind_e;

  function automatic kind_e classify(input logic [CHAR_W-1:0] opc);
    case (opc)
      OPC_BRA:  return K_BRA;
      OPC_BRL:  return K_BRL;
      OPC_STO:  return K_STO;
      OPC_JMP:  return K_JMP;
      OPC_CJMP: return K_CJMP;
      OPC_STOP: return K_STOP;
      default:  return K_NOP;
    endcase
  endfunction
endpackage

// File: rtl/dss_mem.sv
module dss_mem #(
  parameter int DEPTH = 1000,
  parameter int WIDTH = 72,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
    rdata <= cells[raddr];
  end
endmodule

// File: rtl/dss_addr_dec.sv
module dss_addr_dec #(
  parameter int CHAR_W = 6,
  parameter int DIGITS = 3,
  parameter int DEPTH  = 1000,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic [DIGITS*CHAR_W-1:0] digits,
  output logic [AW-1:0]            index
);
  int acc;

  always_comb begin
    acc = 0;
    for (int i = DIGITS - 1; i >= 0; i--) begin
      acc = acc * 10 + int'(digits[i*CHAR_W +: CHAR_W]);
    end
    index = (acc < DEPTH) ? AW'(acc) : '0;
  end
endmodule

// File: rtl/dss_dec_inc.sv
module dss_dec_inc #(
  parameter int CHAR_W = 6,
  parameter int DIGITS = 3
) (
  input  logic [DIGITS*CHAR_W-1:0] value_in,
  output logic [DIGITS*CHAR_W-1:0] value_out
);
  logic [DIGITS:0] carry;
  assign carry[0] = 1'b1;

  for (genvar g = 0; g < DIGITS; g++) begin : g_digit
    logic [CHAR_W-1:0] d;
    logic              top;
    assign d   = value_in[g*CHAR_W +: CHAR_W];
    assign top = (d == CHAR_W'(9));
    assign value_out[g*CHAR_W +: CHAR_W] =
      !carry[g] ? d : (top ? '0 : d + CHAR_W'(1));
    assign carry[g+1] = carry[g] & top;
  end
endmodule

// File: rtl/dual_slot_sequencer.sv
module dual_slot_sequencer
  import dss_pkg::*;
#(
  parameter int DEPTH       = 1000,
  parameter int WORD_CHARS  = 12,
  parameter int ADDR_DIGITS = 3,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int WORD_W = WORD_CHARS * CHAR_W,
  localparam int ADR_W  = ADDR_DIGITS * CHAR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              ld_en,
  input  logic [IDX_W-1:0]  ld_addr,
  input  logic [WORD_W-1:0] ld_word,
  output logic              halted,
  output logic [ADR_W-1:0]  cc_addr,
  output logic [WORD_W-1:0] reg_a,
  output logic [WORD_W-1:0] reg_x,
  output logic [WORD_W-1:0] reg_l
);
  localparam int INS_W = WORD_W / 2;

  stage_e             state;
  logic               right_half;
  logic [INS_W-1:0]   cc;
  logic [INS_W-1:0]   sr;
  logic [WORD_W-1:0]  cr;
  logic [WORD_W-1:0]  rdata;
  logic [ADR_W-1:0]   cc_next;
  logic [IDX_W-1:0]   idx;
  kind_e              kind;
  logic               store_fire;
  logic               mem_we;
  logic [IDX_W-1:0]   mem_wa;
  logic [WORD_W-1:0]  mem_wd;
  logic               unused_mid;

  assign kind       = classify(sr[INS_W-1 -: CHAR_W]);
  assign store_fire = (state == S_EXB) && (kind == K_STO);
  assign unused_mid = ^sr[INS_W-CHAR_W-1 : ADR_W];

  assign mem_we = ld_en | store_fire;
  assign mem_wa = ld_en ? ld_addr : idx;
  assign mem_wd = ld_en ? ld_word : reg_a;

  dss_addr_dec #(.CHAR_W(CHAR_W), .DIGITS(ADDR_DIGITS), .DEPTH(DEPTH)) u_adec (
    .digits(sr[ADR_W-1:0]),
    .index (idx)
  );

  dss_dec_inc #(.CHAR_W(CHAR_W), .DIGITS(ADDR_DIGITS)) u_inc (
    .value_in (cc[ADR_W-1:0]),
    .value_out(cc_next)
  );

  dss_mem #(.DEPTH(DEPTH), .WIDTH(WORD_W)) u_mem (
    .clk  (clk),
    .we   (mem_we),
    .waddr(mem_wa),
    .wdata(mem_wd),
    .raddr(idx),
    .rdata(rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_IDLE;
      halted     <= 1'b1;
      right_half <= 1'b0;
      cc         <= '0;
      sr         <= '0;
      cr         <= '0;
      reg_a      <= '0;
      reg_x      <= '0;
      reg_l      <= '0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          state  <= S_ST1;
          halted <= 1'b0;
        end
        S_ST1: begin
          sr    <= cc;
          state <= S_ST2;
        end
        S_ST2: state <= S_ST3;
        S_ST3: begin
          cr               <= rdata;
          cc[ADR_W-1:0]    <= cc_next;
          state            <= S_LDL;
        end
        S_LDL: begin
          sr         <= cr[WORD_W-1 -: INS_W];
          right_half <= 1'b0;
          state      <= S_EXA;
        end
        S_LDR: begin
          sr         <= cr[INS_W-1:0];
          right_half <= 1'b1;
          state      <= S_EXA;
        end
        S_EXA: state <= S_EXB;
        S_EXB: begin
          state <= right_half ? S_ST1 : S_LDR;
          case (kind)
            K_BRA: begin
              reg_a <= rdata;
              reg_x <= rdata;
            end
            K_BRL: begin
              reg_l <= rdata;
              reg_x <= rdata;
            end
            K_STO:  reg_a <= '0;
            K_JMP:  cc[ADR_W-1:0] <= sr[ADR_W-1:0];
            K_CJMP: if (reg_a == reg_l) cc[ADR_W-1:0] <= sr[ADR_W-1:0];
            K_STOP: begin
              state  <= S_IDLE;
              halted <= 1'b1;
            end
            default: ;
          endcase
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign cc_addr = cc[ADR_W-1:0];
endmodule

// File: rtl/dss_chk.sv
module dss_chk #(
  parameter int CHAR_W      = 6,
  parameter int ADDR_DIGITS = 3,
  parameter int WORD_W      = 72,
  localparam int ADR_W = ADDR_DIGITS * CHAR_W
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              halted,
  input logic [ADR_W-1:0]  cc_addr,
  input logic [WORD_W-1:0] reg_a,
  input logic [WORD_W-1:0] reg_x,
  input logic [WORD_W-1:0] reg_l,
  input logic              store_fire
);
  for (genvar g = 0; g < ADDR_DIGITS; g++) begin : g_dig
    p_cc_digit_r2: assert property (@(posedge clk) disable iff (rst)
      cc_addr[g*CHAR_W +: CHAR_W] <= CHAR_W'(9));
  end

  p_halt_freeze_r8: assert property (@(posedge clk) disable iff (rst)
    (halted && !start) |=> (halted && $stable(cc_addr) && $stable(reg_a)
                            && $stable(reg_x) && $stable(reg_l)));

  p_start_runs_r3: assert property (@(posedge clk) disable iff (rst)
    (halted && start) |=> !halted);

  p_store_clear_r6: assert property (@(posedge clk) disable iff (rst)
    store_fire |=> (reg_a == '0));

  p_x_copy_r4: assert property (@(posedge clk) disable iff (rst)
    !$stable(reg_x) |-> (reg_x == reg_a || reg_x == reg_l));
endmodule

bind dual_slot_sequencer dss_chk #(
  .CHAR_W(dss_pkg::CHAR_W), .ADDR_DIGITS(ADDR_DIGITS), .WORD_W(WORD_W)
) u_chk (
  .clk(clk), .rst(rst), .start(start), .halted(halted), .cc_addr(cc_addr),
  .reg_a(reg_a), .reg_x(reg_x), .reg_l(reg_l), .store_fire(store_fire)
);

// File: tb/tb_dual_slot_sequencer.sv
module tb_dual_slot_sequencer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        ld_en = 1'b0;
  logic [9:0]  ld_addr = '0;
  logic [71:0] ld_word = '0;
  logic        halted;
  logic [17:0] cc_addr;
  logic [71:0] reg_a, reg_x, reg_l;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  always #4 clk = ~clk;

  dual_slot_sequencer dut (
    .clk(clk), .rst(rst), .start(start), .ld_en(ld_en), .ld_addr(ld_addr),
    .ld_word(ld_word), .halted(halted), .cc_addr(cc_addr),
    .reg_a(reg_a), .reg_x(reg_x), .reg_l(reg_l)
  );

  // reference state
  logic [71:0] mm [1000];
  logic [71:0] m_a, m_x, m_l, m_w;
  int          m_cc;
  bit          m_halt, m_run;
  int          m_p;

  localparam logic [71:0] X1 = 72'h0A1B2C3D4E5F607182;
  localparam logic [71:0] X2 = 72'h123456789ABCDEF012;

  function automatic logic [35:0] ins(input int opc, input int adr,
                                      input int c2 = 0, input int c3 = 0);
    return {6'(opc), 6'(c2), 6'(c3), 6'(adr / 100), 6'((adr / 10) % 10), 6'(adr % 10)};
  endfunction

  function automatic logic [17:0] enc(input int v);
    return {6'(v / 100), 6'((v / 10) % 10), 6'(v % 10)};
  endfunction

  task automatic chk(input string tag, input logic [71:0] act, input logic [71:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_op(input logic [35:0] i);
    int m;
    m = int'(i[17:12]) * 100 + int'(i[11:6]) * 10 + int'(i[5:0]);
    case (int'(i[35:30]))
      20: begin m_a = mm[m]; m_x = mm[m]; end
      21: begin m_l = mm[m]; m_x = mm[m]; end
      22: begin mm[m] = m_a; m_a = '0; end
      23: m_cc = m;
      24: if (m_a == m_l) m_cc = m;
      9:  begin m_run = 0; m_halt = 1; end
      default: ;
    endcase
  endtask

  always @(posedge clk) begin
    if (rst) begin
      m_a = '0; m_x = '0; m_l = '0; m_cc = 0; m_halt = 1; m_run = 0; m_p = 0;
    end else begin
      if (ld_en) mm[ld_addr] = ld_word;
      if (!m_run) begin
        if (start) begin m_run = 1; m_halt = 0; m_p = 0; end
      end else begin
        m_p++;
        if (m_p == 3) begin m_w = mm[m_cc]; m_cc = (m_cc + 1) % 1000; end
        if (m_p == 6) run_op(m_w[71:36]);
        if (m_run && m_p == 9) begin run_op(m_w[35:0]); m_p = 0; end
      end
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R8 halted", {71'd0, halted}, {71'd0, m_halt});
      chk("R2 cc_addr", {54'd0, cc_addr}, {54'd0, enc(m_cc)});
      chk("R3 reg_a", reg_a, m_a);
      chk("R4 reg_x", reg_x, m_x);
      chk("R5 reg_l", reg_l, m_l);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected<=20000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic load(input int a, input logic [71:0] w);
    ld_en = 1; ld_addr = 10'(a); ld_word = w;
    @(negedge clk);
    ld_en = 0;
  endtask

  task automatic go_and_wait;
    start = 1;
    @(negedge clk);
    start = 0;
    for (int k = 0; k < 600 && !halted; k++) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    // R1 reset state
    chk("R1 halted", {71'd0, halted}, 72'd1);
    chk("R1 cc", {54'd0, cc_addr}, 72'd0);
    chk("R1 reg_a", reg_a, '0);
    chk("R1 reg_x", reg_x, '0);
    chk("R1 reg_l", reg_l, '0);

    // R12 load port fills memory
    for (int i = 0; i < 1000; i++) load(i, '0);
    load(100, X1);
    load(101, X2);
    load(0,  {ins(20, 100, 5, 7), ins(22, 102)});   // R11 chars 2,3 ignored
    load(1,  {ins(20, 101), ins(22, 100)});
    load(2,  {ins(20, 102), ins(22, 101)});
    load(3,  {ins(0, 555), ins(30, 100)});          // R7 skip and unknown
    load(4,  {ins(21, 100), ins(20, 100)});
    load(5,  {ins(0, 0), ins(24, 8)});              // R10 equal -> taken
    load(6,  {ins(9, 0), ins(9, 0)});
    load(8,  {ins(21, 101), ins(24, 10)});          // R10 unequal -> skip
    load(9,  {ins(0, 0), ins(23, 12)});             // R9
    load(10, {ins(9, 0), ins(9, 0)});
    load(12, {ins(9, 0), ins(20, 100)});            // R8 right half not run
    load(13, {ins(20, 101), ins(21, 100)});
    load(14, {ins(22, 200), ins(9, 0)});
    load(15, {ins(20, 200), ins(23, 999)});
    load(999, {ins(0, 0), ins(0, 0)});

    go_and_wait;
    chk("R8 halted after stop", {71'd0, halted}, 72'd1);
    chk("R9 R10 cc after branches", {54'd0, cc_addr}, {54'd0, enc(13)});
    chk("R6 R11 swap into reg_a", reg_a, X2);
    chk("R5 reg_l", reg_l, X1);
    chk("R4 reg_x", reg_x, X1);
    repeat (5) @(negedge clk);
    chk("R8 hold cc", {54'd0, cc_addr}, {54'd0, enc(13)});
    chk("R7 R8 hold reg_a", reg_a, X2);

    go_and_wait;                                     // R8 resume from 013
    chk("R6 store clears reg_a", reg_a, '0);
    chk("R6 swapped cell 100", reg_l, X2);
    chk("R4 reg_x", reg_x, X2);
    chk("R8 cc after resume", {54'd0, cc_addr}, {54'd0, enc(15)});

    load(0, {ins(9, 0), ins(9, 0)});
    go_and_wait;
    chk("R6 stored word read back", reg_a, X1);
    chk("R2 wrap 999 to 000", {54'd0, cc_addr}, {54'd0, enc(1)});
    chk("R8 halted", {71'd0, halted}, 72'd1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule